// File: doc/BRIEF.md
# SPI Interrupt Aggregator

This block gathers the interrupt conditions of an SPI peripheral into one request line. Level conditions come from the two FIFO occupancy counts, which are compared against programmable thresholds. Edge conditions come from the busy flag. Pulse conditions come from the datapath, such as frame completion, receive timeout, DMA completion and parity fault. Each condition sets a sticky raw status bit. A per-source enable mask selects which raw bits reach the registered request output `irq`.

Software uses a small word-addressed register bus. Through it, software reads the raw and masked status, programs the mask and the two threshold codes, and clears or forces status bits. The block also gates the receive FIFO write strobe. A frame that completes while the receive FIFO is full raises the overflow bit and is not pushed, so the stored data stays intact.

Top module: `spi_irq_agg`

## Requirements
- R1: Status bit positions are: 0 TX service, 1 RX service, 2 RX timeout, 3 RX overflow, 4 TX empty, 5 TX DMA done, 6 RX DMA done, 7 idle, 8 parity error. All bits are 0 after reset. Once set, a bit stays 1 until software clears it.
- R2: Bit 0 is set on every cycle in which `tx_level` is at or below the TX threshold. This happens whether `spi_en` is 0 or 1.
- R3: Bit 1 is set on every cycle in which `spi_en` is 1 and `rx_level` is at or above the RX threshold. It is not set while `spi_en` is 0.
- R4: Threshold code 0, 1, 2, 3 and 4 gives a level of 1, 2, 4, 6 and 7 entries for the default depth of 8. Codes 5 to 7 give 4 entries.
- R5: When `rx_frame_done` is high and `rx_level` equals the depth (8), bit 3 is set and `rx_push` stays low. When `rx_frame_done` is high and the FIFO has room, `rx_push` is high and bit 3 is not set.
- R6: Bit 7 is set only in the cycle after `busy` goes from 1 to 0. Busy rising, or busy held at one value, leaves it 0.
- R7: Pulses on `rx_timeout`, `tx_dma_done`, `rx_dma_done` and `parity_err` set bits 2, 5, 6 and 8 respectively, and no other bit.
- R8: Bit 4 is set when `spi_en` is 1 and `tx_level` is 0.
- R9: Masked status equals raw AND mask. `irq` is 1 one cycle after that AND becomes nonzero, and is 0 while it is zero.
- R10: Writing 1s to the clear word clears those raw bits. Writing 1s to the set word sets them. Both words read as 0. An event arriving in the same cycle as a clear leaves its bit at 1.
- R11: Word addresses are: 0 raw (read only), 1 masked (read only), 2 mask (bits 8:0, reset 0), 3 clear, 4 set, 5 thresholds (TX code in bits 2:0, RX code in bits 6:4, each reset to 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_en | input | 1 | SPI enabled |
| busy | input | 1 | Transfer in progress |
| tx_level | input | 4 | TX FIFO occupancy |
| rx_level | input | 4 | RX FIFO occupancy |
| rx_frame_done | input | 1 | Received frame completed (pulse) |
| rx_timeout | input | 1 | Receive timeout (pulse) |
| tx_dma_done | input | 1 | TX DMA completed (pulse) |
| rx_dma_done | input | 1 | RX DMA completed (pulse) |
| parity_err | input | 1 | Parity fault (pulse) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| rx_push | output | 1 | Write enable to the RX FIFO |
| irq | output | 1 | Combined interrupt request |

## Verification
The threshold logic is driven with levels one step above and exactly at each threshold code. This separates an at-or-below comparison from a strict one and catches a wrong code-to-level mapping. The enable-gated sources are tried with `spi_en` both low and high, which shows that TX service ignores the enable while RX service and TX empty follow it. Busy is moved in both directions, and each pulse source is fired on its own, to show that every source lands on its own bit. A clear is issued in the same cycle as a parity pulse, and a masked source is set next to an unmasked one, to check the clear priority and the mask gating of `irq`.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int NSRC = 9;

  localparam int B_TXS  = 0;
  localparam int B_RXS  = 1;
  localparam int B_RXTO = 2;
  localparam int B_OVF  = 3;
  localparam int B_TXE  = 4;
  localparam int B_TDMA = 5;
  localparam int B_RDMA = 6;
  localparam int B_IDLE = 7;
  localparam int B_PAR  = 8;

  localparam logic [2:0] A_RAW  = 3'd0;
  localparam logic [2:0] A_MSTS = 3'd1;
  localparam logic [2:0] A_MASK = 3'd2;
  localparam logic [2:0] A_CLR  = 3'd3;
  localparam logic [2:0] A_SET  = 3'd4;
  localparam logic [2:0] A_THR  = 3'd5;

  // Fraction of the FIFO depth selected by a threshold code
  function automatic int unsigned thr_level(input logic [2:0] code, input int unsigned depth);
    case (code)
      3'd0:    return depth / 8;
      3'd1:    return depth / 4;
      3'd2:    return depth / 2;
      3'd3:    return (3 * depth) / 4;
      3'd4:    return (7 * depth) / 8;
      default: return depth / 2;
    endcase
  endfunction
endpackage

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [NSRC-1:0] mask_q,
  output logic [2:0]      tx_code_q,
  output logic [2:0]      rx_code_q,
  output logic [NSRC-1:0] clr_pls,
  output logic [NSRC-1:0] set_pls
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata[DW-1:NSRC]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      tx_code_q <= 3'd2;
      rx_code_q <= 3'd2;
    end else if (wr_en) begin
      if (addr == A_MASK) mask_q <= wdata[NSRC-1:0];
      if (addr == A_THR) begin
        tx_code_q <= wdata[2:0];
        rx_code_q <= wdata[6:4];
      end
    end
  end

  assign clr_pls = (wr_en && addr == A_CLR) ? wdata[NSRC-1:0] : '0;
  assign set_pls = (wr_en && addr == A_SET) ? wdata[NSRC-1:0] : '0;
endmodule

// File: rtl/spi_irq_detect.sv
module spi_irq_detect
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spi_en,
  input  logic            busy,
  input  logic [LW-1:0]   tx_level,
  input  logic [LW-1:0]   rx_level,
  input  logic [2:0]      tx_code,
  input  logic [2:0]      rx_code,
  input  logic            rx_frame_done,
  input  logic            rx_timeout,
  input  logic            tx_dma_done,
  input  logic            rx_dma_done,
  input  logic            parity_err,
  output logic [NSRC-1:0] evt,
  output logic            rx_push
);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  logic [LW-1:0] tx_thr, rx_thr;
  logic busy_q;
  logic evt_tx_srv, evt_rx_srv, evt_ovf, evt_tx_empty, evt_idle, rx_full;

  assign tx_thr = LW'(thr_level(tx_code, DEPTH));
  assign rx_thr = LW'(thr_level(rx_code, DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy;
  end

  assign rx_full      = (rx_level >= FULL);
  assign evt_tx_srv   = (tx_level <= tx_thr);
  assign evt_rx_srv   = spi_en && (rx_level >= rx_thr);
  assign evt_ovf      = rx_frame_done && rx_full;
  assign evt_tx_empty = spi_en && (tx_level == '0);
  assign evt_idle     = busy_q && !busy;
  assign rx_push      = rx_frame_done && !rx_full;

  always_comb begin
    evt         = '0;
    evt[B_TXS]  = evt_tx_srv;
    evt[B_RXS]  = evt_rx_srv;
    evt[B_RXTO] = rx_timeout;
    evt[B_OVF]  = evt_ovf;
    evt[B_TXE]  = evt_tx_empty;
    evt[B_TDMA] = tx_dma_done;
    evt[B_RDMA] = rx_dma_done;
    evt[B_IDLE] = evt_idle;
    evt[B_PAR]  = parity_err;
  end

  // R5: the FIFO is never written when it has no room
  p_push_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> (rx_level < FULL));

  // R6: idle fires only on a falling busy
  p_idle_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_idle |-> $fell(busy));
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] raw_q,
  output logic            irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= (raw_q & ~clr) | set | evt;
      irq_q <= |(raw_q & mask);
    end
  end

  // R1: latched bits survive unless cleared
  p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(raw_q & ~clr)) == $past(raw_q & ~clr)));

  // R10: an event beats a simultaneous clear
  p_evt_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((raw_q & $past(evt)) == $past(evt)));

  // R9: no request without an enabled source
  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> ($past(mask) != '0));
endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
  import spi_irq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_en,
  input  logic          busy,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          rx_frame_done,
  input  logic          rx_timeout,
  input  logic          tx_dma_done,
  input  logic          rx_dma_done,
  input  logic          parity_err,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          rx_push,
  output logic          irq
);
  logic [NSRC-1:0] mask_q, clr_pls, set_pls, evt, raw_q, msk_sts;
  logic [2:0] tx_code, rx_code;

  spi_irq_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mask_q(mask_q), .tx_code_q(tx_code), .rx_code_q(rx_code),
    .clr_pls(clr_pls), .set_pls(set_pls)
  );

  spi_irq_detect #(.DEPTH(DEPTH)) det_i (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .busy(busy),
    .tx_level(tx_level), .rx_level(rx_level), .tx_code(tx_code), .rx_code(rx_code),
    .rx_frame_done(rx_frame_done), .rx_timeout(rx_timeout),
    .tx_dma_done(tx_dma_done), .rx_dma_done(rx_dma_done), .parity_err(parity_err),
    .evt(evt), .rx_push(rx_push)
  );

  spi_irq_status sts_i (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr_pls), .set(set_pls),
    .mask(mask_q), .raw_q(raw_q), .irq_q(irq)
  );

  assign msk_sts = raw_q & mask_q;

  always_comb begin
    case (bus_addr)
      A_RAW:   bus_rdata = {{(DW-NSRC){1'b0}}, raw_q};
      A_MSTS:  bus_rdata = {{(DW-NSRC){1'b0}}, msk_sts};
      A_MASK:  bus_rdata = {{(DW-NSRC){1'b0}}, mask_q};
      A_THR:   bus_rdata = {{(DW-7){1'b0}}, rx_code, 1'b0, tx_code};
      default: bus_rdata = '0;
    endcase
  end

  // R9: a live masked source raises the request on the next cycle
  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_sts != '0) |=> irq);
endmodule

// File: tb/spi_irq_agg_tb.sv
`timescale 1ns/1ps
module spi_irq_agg_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_en = 0, busy = 0, rx_frame_done = 0, rx_timeout = 0;
  logic tx_dma_done = 0, rx_dma_done = 0, parity_err = 0, bus_wr = 0;
  logic [3:0] tx_level = 4'd8, rx_level = 4'd0;
  logic [2:0] bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0, bus_rdata;
  logic rx_push, irq;
  int errs = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .spi_en(spi_en), .busy(busy),
    .tx_level(tx_level), .rx_level(rx_level), .rx_frame_done(rx_frame_done),
    .rx_timeout(rx_timeout), .tx_dma_done(tx_dma_done), .rx_dma_done(rx_dma_done),
    .parity_err(parity_err), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_push(rx_push), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic quiet();
    spi_en = 0; busy = 0; tx_level = 8; rx_level = 0;
    rx_frame_done = 0; rx_timeout = 0; tx_dma_done = 0; rx_dma_done = 0; parity_err = 0;
    tick();
    wr(3'd3, 32'h1FF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1", "raw after reset", v, 0);
    rd(3'd2, v); chk("R11", "mask after reset", v, 0);
    rd(3'd5, v); chk("R11", "thresholds after reset", v, 32'h22);
    chk("R9", "irq after reset", irq, 0);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R11", "mask width", v, 32'h1FF);
    wr(3'd2, 0);
  endtask

  task automatic t_tx_srv();
    logic [31:0] v;
    quiet();
    tx_level = 5; tick(); wr(3'd3, 32'h1FF);
    rd(3'd0, v); chk("R2", "tx level above threshold", v[0], 0);
    tx_level = 4; tick();
    rd(3'd0, v); chk("R2", "tx at threshold, disabled", v[0], 1);
  endtask

  task automatic t_rx_srv();
    logic [31:0] v;
    quiet();
    rx_level = 4; tick(); tick();
    rd(3'd0, v); chk("R3", "rx at threshold, disabled", v[1], 0);
    spi_en = 1; tick();
    rd(3'd0, v); chk("R3", "rx at threshold, enabled", v[1], 1);
    rx_level = 3; tick(); wr(3'd3, 32'h1FF);
    rd(3'd0, v); chk("R3", "rx below threshold", v[1], 0);
  endtask

  task automatic t_thresholds();
    logic [31:0] v;
    int tbl[6] = '{1, 2, 4, 6, 7, 4};
    for (int c = 0; c < 6; c++) begin
      quiet();
      wr(3'd5, (c << 4) | c);
      rd(3'd5, v); chk("R11", "threshold readback", v, (c << 4) | c);
      spi_en = 1;
      tx_level = 4'(tbl[c] + 1); rx_level = 4'(tbl[c] - 1);
      tick(); wr(3'd3, 32'h1FF);
      rd(3'd0, v); chk("R4", $sformatf("code %0d off by one", c), v[1:0], 0);
      tx_level = 4'(tbl[c]); rx_level = 4'(tbl[c]);
      tick();
      rd(3'd0, v); chk("R4", $sformatf("code %0d at level", c), v[1:0], 2'b11);
    end
    wr(3'd5, 32'h22);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    quiet();
    rx_level = 7; rx_frame_done = 1; #1;
    chk("R5", "push with room", rx_push, 1);
    tick(); rx_frame_done = 0;
    rd(3'd0, v); chk("R5", "no overflow with room", v[3], 0);
    rx_level = 8; rx_frame_done = 1; #1;
    chk("R5", "no push when full", rx_push, 0);
    tick(); rx_frame_done = 0;
    rd(3'd0, v); chk("R5", "overflow when full", v[3], 1);
  endtask

  task automatic t_idle();
    logic [31:0] v;
    quiet();
    busy = 1; tick(); tick();
    rd(3'd0, v); chk("R6", "busy rise and hold", v[7], 0);
    busy = 0; tick();
    rd(3'd0, v); chk("R6", "busy fall", v[7], 1);
    wr(3'd3, 32'h1FF); tick();
    rd(3'd0, v); chk("R6", "busy low held", v[7], 0);
  endtask

  task automatic t_strobes();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      quiet();
      case (k)
        0: rx_timeout = 1;
        1: tx_dma_done = 1;
        2: rx_dma_done = 1;
        default: parity_err = 1;
      endcase
      tick();
      rx_timeout = 0; tx_dma_done = 0; rx_dma_done = 0; parity_err = 0;
      rd(3'd0, v);
      case (k)
        0: chk("R7", "rx timeout bit", v, 32'h004);
        1: chk("R7", "tx dma bit", v, 32'h020);
        2: chk("R7", "rx dma bit", v, 32'h040);
        default: chk("R7", "parity bit", v, 32'h100);
      endcase
      tick();
      rd(3'd0, v); chk("R1", "bit sticky after pulse", v != 0, 1);
    end
  endtask

  task automatic t_tx_empty();
    logic [31:0] v;
    quiet();
    tx_level = 0; tick(); tick();
    rd(3'd0, v); chk("R8", "empty while disabled", v[4], 0);
    spi_en = 1; tick();
    rd(3'd0, v); chk("R8", "empty while enabled", v[4], 1);
    tx_level = 8; tick(); wr(3'd3, 32'h1FF);
    rd(3'd0, v); chk("R8", "not empty", v[4], 0);
  endtask

  task automatic t_mask_irq();
    logic [31:0] v;
    quiet();
    wr(3'd2, 32'h100);
    rx_dma_done = 1; tick(); rx_dma_done = 0;
    rd(3'd1, v); chk("R9", "masked-off source hidden", v, 0);
    tick(); chk("R9", "no irq for masked-off source", irq, 0);
    parity_err = 1; tick(); parity_err = 0;
    rd(3'd1, v); chk("R9", "masked status", v, 32'h100);
    chk("R9", "irq one cycle late", irq, 0);
    tick(); chk("R9", "irq raised", irq, 1);
    wr(3'd2, 0); tick();
    chk("R9", "irq dropped with mask", irq, 0);
    rd(3'd0, v); chk("R1", "raw unaffected by mask", v, 32'h140);
  endtask

  task automatic t_clr_set();
    logic [31:0] v;
    quiet();
    wr(3'd4, 32'h0A4);
    rd(3'd0, v); chk("R10", "set word", v, 32'h0A4);
    rd(3'd4, v); chk("R10", "set word reads 0", v, 0);
    rd(3'd3, v); chk("R10", "clear word reads 0", v, 0);
    wr(3'd3, 32'h004);
    rd(3'd0, v); chk("R10", "partial clear", v, 32'h0A0);
    parity_err = 1; wr(3'd3, 32'h100); parity_err = 0;
    rd(3'd0, v); chk("R10", "event beats clear", v[8], 1);
    wr(3'd3, 32'h100);
    rd(3'd0, v); chk("R10", "clear after event", v[8], 0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_tx_srv();
    t_rx_srv();
    t_thresholds();
    t_overflow();
    t_idle();
    t_strobes();
    t_tx_empty();
    t_mask_irq();
    t_clr_set();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule